// File: doc/BRIEF.md
# Dual-Mode Serial LED Stream Driver

This block sends a vector of LED status bits off chip as an endless serial stream on three pins: a shift clock, a data line and a latch strobe. One global mode input picks between two receiver families. The first is a display-driver chip that takes a fixed 36-clock frame with a leading start bit, true-polarity data and no strobe. The second is a chain of four 8-bit latching shift registers, which takes inverted data and a store strobe after each frame.

The shift clock comes from the system clock through a programmable half-period divider. The clock has a 50 % duty cycle and never stops. Data and strobe are launched as the shift clock falls, so they are settled for the whole high half in which the receiver samples on the rising edge. At the start of each frame the LED vector and the mode are captured into holding registers. Frames follow each other with no idle gap. The LED vector is a level-type status input and not a stream, so it has no valid/ready handshake. It is sampled at frame starts and nothing is ever held back.

Top module: `led_serial_drv`

## Requirements
- R1: While reset is asserted and after it is released, until the first serial clock edge, the serial clock, data and latch outputs are all low.
- R2: The serial clock toggles every H system clocks, where H is the divider input and a value of 0 counts as 1. Rising edges are therefore exactly 2*H system clocks apart, in both modes and across frame boundaries.
- R3: Data and latch change only while the serial clock is low. They never change in the cycle in which the clock is high or rises.
- R4: Mode 0 (mode input low) frame: 36 serial clocks. Rise 0 carries a 1 (start bit). Rises 1 to 30 carry LED bits 0 to 29 in ascending order. Rises 31 to 35 carry 0. The line level equals the bit.
- R5: Mode 1 (mode input high) frame: 33 serial clocks. Rises 0 to 29 carry LED bits 0 to 29. Rises 30 and 31 are padding with value 0. Rise 32 is the strobe slot with value 0. The line level is the inverse of the bit, so a padding or idle bit reads high.
- R6: The latch output is high for exactly the serial period of slot 32 of a mode 1 frame. It rises together with the clock fall that opens that slot and falls with the next clock fall. In mode 0 the latch never rises.
- R7: The LED vector is captured at the clock fall that opens slot 0. Changes to it during a frame do not affect the bits of that frame.
- R8: The mode input is taken only at a frame start. A frame runs to its end in the mode it started with, and the next frame follows on the very next serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_vec_i | input | LED_N (30) | LED status bits, bit 0 sent first |
| mode_sel_i | input | 1 | 0: display-driver frame, 1: shift-register chain frame |
| half_div_i | input | DIV_W (16) | Serial clock half-period in system clocks (0 treated as 1) |
| ser_clk_o | output | 1 | Continuous serial shift clock |
| ser_data_o | output | 1 | Serial data, launched on the falling clock edge |
| ser_latch_o | output | 1 | Store strobe for the shift-register chain (mode 1 only) |

## Verification
The divider-gap assertion only holds while the divider input is constant, and is guarded by a stability term. The bench therefore changes the divider only while reset is asserted, starting a new session each time. No assertion assumes anything about the LED vector or the mode input. The stimulus flips both in the middle of frames, to random values and to inverted values, and sets the real next values just after the final rising edge of a frame. This places each change between the last sampled bit and the capturing clock fall.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

  typedef enum logic {
    MODE_DRIVER   = 1'b0,
    MODE_SHIFTREG = 1'b1
  } ser_mode_e;

  localparam int unsigned DEF_LED_N    = 30;
  localparam int unsigned DEF_DIV_W    = 16;
  localparam int unsigned DEF_M0_TAIL  = 5;
  localparam int unsigned DEF_M1_REGS  = 4;
  localparam int unsigned DEF_REG_BITS = 8;

endpackage

// File: rtl/led_tick_div.sv
module led_tick_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= half_eff - DIV_W'(1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && half_eff > DIV_W'(1) && $stable(half_i)) |=> !tick_o);

endmodule

// File: rtl/led_frame_ctl.sv
module led_frame_ctl
  import led_ser_pkg::*;
#(
  parameter int unsigned LED_N    = 30,
  parameter int unsigned SLOT_W   = 6,
  parameter int unsigned M0_SLOTS = 36,
  parameter int unsigned M1_SLOTS = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              mode_i,
  input  logic [LED_N-1:0]  leds_i,
  output logic              sclk_o,
  output logic              launch_o,
  output ser_mode_e         mode_o,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output ser_mode_e         mode_nxt_o,
  output logic [LED_N-1:0]  hold_nxt_o
);

  logic              fall_due_q;
  logic [SLOT_W-1:0] slot_q;
  ser_mode_e         mode_q;
  logic [LED_N-1:0]  hold_q;
  logic [SLOT_W-1:0] last_slot;
  logic              wrap;

  always_comb begin
    last_slot = (mode_q == MODE_SHIFTREG) ? SLOT_W'(M1_SLOTS - 1)
                                          : SLOT_W'(M0_SLOTS - 1);
    wrap      = (slot_q == last_slot);
    launch_o  = tick_i && fall_due_q;
    slot_nxt_o = slot_q;
    mode_nxt_o = mode_q;
    hold_nxt_o = hold_q;
    if (launch_o) begin
      if (wrap) begin
        slot_nxt_o = '0;
        mode_nxt_o = ser_mode_e'(mode_i);
        hold_nxt_o = leds_i;
      end else begin
        slot_nxt_o = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o     <= 1'b0;
      fall_due_q <= 1'b1;
      slot_q     <= SLOT_W'(M0_SLOTS - 1);
      mode_q     <= MODE_DRIVER;
      hold_q     <= '0;
    end else if (tick_i) begin
      sclk_o     <= !fall_due_q;
      fall_due_q <= !fall_due_q;
      slot_q     <= slot_nxt_o;
      mode_q     <= mode_nxt_o;
      hold_q     <= hold_nxt_o;
    end
  end

  assign mode_o = mode_q;

  // R8
  mode_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> (slot_q == '0 && $past(launch_o)));

  // R7
  hold_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_q) |-> (slot_q == '0));

  // R2
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> $past(tick_i));

  // R5
  m1_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SHIFTREG) |-> (slot_q < SLOT_W'(M1_SLOTS)));

endmodule

// File: rtl/led_bit_sel.sv
module led_bit_sel
  import led_ser_pkg::*;
#(
  parameter int unsigned LED_N    = 30,
  parameter int unsigned SLOT_W   = 6,
  parameter int unsigned M0_SLOTS = 36,
  parameter int unsigned M1_SLOTS = 33
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  ser_mode_e         mode_i,
  input  logic [LED_N-1:0]  hold_i,
  output logic              line_o,
  output logic              latch_o
);

  logic [M0_SLOTS-1:0] pat_drv;
  logic [M1_SLOTS-1:0] pat_shr;
  logic                raw;

  for (genvar i = 0; i < M0_SLOTS; i++) begin : g_drv
    if (i == 0) begin : g_start
      assign pat_drv[i] = 1'b1;
    end else if (i <= LED_N) begin : g_led
      assign pat_drv[i] = hold_i[i-1];
    end else begin : g_tail
      assign pat_drv[i] = 1'b0;
    end
  end

  for (genvar j = 0; j < M1_SLOTS; j++) begin : g_shr
    if (j < LED_N) begin : g_led
      assign pat_shr[j] = hold_i[j];
    end else begin : g_pad
      assign pat_shr[j] = 1'b0;
    end
  end

  always_comb begin
    raw     = 1'b0;
    latch_o = 1'b0;
    if (mode_i == MODE_SHIFTREG) begin
      if (slot_i < SLOT_W'(M1_SLOTS)) raw = pat_shr[slot_i];
      latch_o = (slot_i == SLOT_W'(M1_SLOTS - 1));
      line_o  = !raw;
    end else begin
      if (slot_i < SLOT_W'(M0_SLOTS)) raw = pat_drv[slot_i];
      line_o = raw;
    end
  end

endmodule

// File: rtl/led_out_stage.sv
module led_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic sclk_i,
  input  logic line_i,
  input  logic latch_i,
  output logic line_o,
  output logic latch_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o  <= 1'b0;
      latch_o <= 1'b0;
    end else if (launch_i) begin
      line_o  <= line_i;
      latch_o <= latch_i;
    end
  end

  // R3
  data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> !sclk_i);

  // R3
  latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_o) |-> !sclk_i);

endmodule

// File: rtl/led_serial_drv.sv
module led_serial_drv
  import led_ser_pkg::*;
#(
  parameter int unsigned DIV_W    = DEF_DIV_W,
  parameter int unsigned LED_N    = DEF_LED_N,
  parameter int unsigned M0_TAIL  = DEF_M0_TAIL,
  parameter int unsigned M1_REGS  = DEF_M1_REGS,
  parameter int unsigned REG_BITS = DEF_REG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LED_N-1:0] led_vec_i,
  input  logic             mode_sel_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             ser_clk_o,
  output logic             ser_data_o,
  output logic             ser_latch_o
);

  localparam int unsigned M0_SLOTS = 1 + LED_N + M0_TAIL;
  localparam int unsigned M1_DATA  = M1_REGS * REG_BITS;
  localparam int unsigned M1_SLOTS = M1_DATA + 1;
  localparam int unsigned MAX_SLOT = (M0_SLOTS > M1_SLOTS) ? M0_SLOTS : M1_SLOTS;
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOT + 1);

  logic              tick;
  logic              launch;
  ser_mode_e         mode_cur;
  logic [SLOT_W-1:0] slot_nxt;
  ser_mode_e         mode_nxt;
  logic [LED_N-1:0]  hold_nxt;
  logic              line_nxt;
  logic              latch_nxt;

  led_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .half_i (half_div_i),
    .tick_o (tick)
  );

  led_frame_ctl #(
    .LED_N(LED_N), .SLOT_W(SLOT_W), .M0_SLOTS(M0_SLOTS), .M1_SLOTS(M1_SLOTS)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .mode_i     (mode_sel_i),
    .leds_i     (led_vec_i),
    .sclk_o     (ser_clk_o),
    .launch_o   (launch),
    .mode_o     (mode_cur),
    .slot_nxt_o (slot_nxt),
    .mode_nxt_o (mode_nxt),
    .hold_nxt_o (hold_nxt)
  );

  led_bit_sel #(
    .LED_N(LED_N), .SLOT_W(SLOT_W), .M0_SLOTS(M0_SLOTS), .M1_SLOTS(M1_SLOTS)
  ) u_sel (
    .slot_i  (slot_nxt),
    .mode_i  (mode_nxt),
    .hold_i  (hold_nxt),
    .line_o  (line_nxt),
    .latch_o (latch_nxt)
  );

  led_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .sclk_i   (ser_clk_o),
    .line_i   (line_nxt),
    .latch_i  (latch_nxt),
    .line_o   (ser_data_o),
    .latch_o  (ser_latch_o)
  );

  initial begin
    pad_fit_chk: assert (M1_DATA >= LED_N);
  end

  // R6
  latch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch_o |-> (mode_cur == MODE_SHIFTREG));

  // R6
  latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch_o) |-> !ser_clk_o);

endmodule

// File: tb/test_led_serial_drv.sv
`timescale 1ns/1ps
module test_led_serial_drv;

  localparam int LED_N = 30;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LED_N-1:0] leds = '0;
  logic             mode = 1'b0;
  logic [DIV_W-1:0] div = 16'd1;
  logic             ser_clk, ser_dat, ser_lat;

  always #2 clk = ~clk;

  led_serial_drv i_led_serial_drv (
    .clk(clk), .rst_n(rst_n), .led_vec_i(leds), .mode_sel_i(mode),
    .half_div_i(div), .ser_clk_o(ser_clk), .ser_data_o(ser_dat),
    .ser_latch_o(ser_lat)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, k = 0, frames = 0;
  bit seen_rise = 0, timeout = 0, disturbed = 0;
  logic p_clk, p_dat, p_lat;
  logic [40:0] got_d, got_l;
  logic cur_mode;
  logic [LED_N-1:0] cur_bits;
  int sess = 0;

  function automatic int flen(input logic m);
    return m ? 33 : 36;
  endfunction

  function automatic logic exp_line(input logic m, input logic [LED_N-1:0] b, input int p);
    if (!m) begin
      if (p == 0) return 1'b1;
      if (p <= 30) return b[p-1];
      return 1'b0;
    end
    if (p < 30) return !b[p];
    return 1'b1;
  endfunction

  function automatic logic exp_latch(input logic m, input int p);
    return m && (p == 32);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pick_next();
    int h = (div == 0) ? 1 : int'(div);
    if (sess == 0 && frames < 4) begin
      case (frames)
        0: leds = '1;
        1: leds = '0;
        2: leds = 30'h1;
        default: leds = 30'h2000_0000;
      endcase
      mode = frames[0];
    end else begin
      leds = LED_N'($urandom);
      mode = 1'($urandom % 2);
    end
    if (h < 0) leds = '0;
    cur_mode = mode;
    cur_bits = leds;
  endtask

  task automatic frame_done();
    logic [40:0] ed, el;
    int n = flen(cur_mode);
    bit ok_d = 1, ok_l = 1;
    ed = '0; el = '0;
    for (int p = 0; p < n; p++) begin
      ed[p] = exp_line(cur_mode, cur_bits, p);
      el[p] = exp_latch(cur_mode, p);
      if (got_d[p] !== ed[p]) ok_d = 0;
      if (got_l[p] !== el[p]) ok_l = 0;
    end
    if (disturbed)
      check(ok_d, "R7/R8 frame held despite mid-frame input change", 64'(got_d), 64'(ed));
    else if (cur_mode)
      check(ok_d, "R5 shift-register frame data", 64'(got_d), 64'(ed));
    else
      check(ok_d, "R4 driver frame data", 64'(got_d), 64'(ed));
    check(ok_l, "R6 latch slot pattern", 64'(got_l), 64'(el));
    frames++;
    disturbed = 0;
    pick_next();
    k = 0;
  endtask

  task automatic step();
    int h;
    @(negedge clk);
    cyc++;
    h = (div == 0) ? 1 : int'(div);
    if (cyc > 150000 && !timeout) begin
      timeout = 1;
      check(0, "R2 watchdog expired", 64'(cyc), 64'(0));
    end
    if (rst_n) begin
      if (ser_dat !== p_dat || ser_lat !== p_lat)
        check(ser_clk === 1'b0, "R3 launch only while clock low", 64'(ser_clk), 64'(0));
      if (!p_clk && ser_clk) begin
        if (seen_rise)
          check(cyc - last_rise == 2 * h, "R2 rise spacing", 64'(cyc - last_rise), 64'(2 * h));
        if (k == 0 && !seen_rise && cur_mode == 1'b0 && frames == 0)
          check(ser_dat === 1'b1, "R4 start bit of first frame", 64'(ser_dat), 64'(1));
        seen_rise = 1;
        last_rise = cyc;
        got_d[k] = ser_dat;
        got_l[k] = ser_lat;
        k++;
        if (k == 10 && ($urandom % 2 == 1)) begin
          leds = ~cur_bits;
          mode = !cur_mode;
          disturbed = 1;
        end
        if (k == flen(cur_mode)) frame_done();
      end
    end
    p_clk = ser_clk;
    p_dat = ser_dat;
    p_lat = ser_lat;
  endtask

  task automatic run_session(input logic [DIV_W-1:0] d, input int nframes);
    rst_n = 1'b0;
    div = d;
    mode = 1'(sess % 2);
    leds = LED_N'($urandom);
    repeat (3) step();
    check(ser_clk === 0 && ser_dat === 0 && ser_lat === 0, "R1 outputs low in reset",
          {61'd0, ser_clk, ser_dat, ser_lat}, 64'(0));
    cur_mode = mode;
    cur_bits = leds;
    k = 0; frames = 0; seen_rise = 0; disturbed = 0;
    p_clk = 0; p_dat = 0; p_lat = 0;
    rst_n = 1'b1;
    step();
    check(ser_clk === 0 && ser_dat === 0 && ser_lat === 0, "R1 outputs low after release",
          {61'd0, ser_clk, ser_dat, ser_lat}, 64'(0));
    while (frames < nframes && !timeout) step();
  endtask

  initial begin
    void'($urandom(32'd7361));
    sess = 0; run_session(16'd1, 10);
    sess = 1; run_session(16'd3, 8);
    sess = 2; run_session(16'd0, 8);
    sess = 3; run_session(16'd2, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule